// File: doc/BRIEF.md
# Burst address sequencer

This block produces the word address for a four-beat burst into a synchronous cache memory. An access opens when one of two active-low address strobes is seen at a rising clock edge. The block then captures the presented address and the burst order in effect at that moment. One strobe belongs to the processor and counts only while the first chip select is asserted. The other belongs to the cache controller and always counts.

After capture, each cycle in which the active-low advance input is asserted steps the burst by one beat. Only the two lowest address bits change. They follow either a linear wraparound order or an interleaved order, in which the start bits are exclusive-ORed with the beat number. The upper address bits are held for the whole burst. The outputs are the full current address and the index of the current beat.

Top module: `burst_addr_seq`

## Requirements
- R1: When the controller strobe (ctrl_strb_n) is low at a rising edge, the next cycle shows addr_o equal to the addr_i presented at that edge and beat_o equal to 0, whatever the level of cs1_n.
- R2: The processor strobe (proc_strb_n) low loads the address in the same way only while cs1_n is low. While cs1_n is high it is ignored, and addr_o and beat_o keep their values if no other cause changes them.
- R3: Each cycle with adv_n low and no load raises beat_o by one modulo 4. Four advances after a load bring addr_o back to the captured start address.
- R4: With order_sel high (1 = interleaved) at load time, the two low bits of addr_o at beat k equal the captured start low bits XOR k.
- R5: With order_sel low (0 = linear) at load time, the two low bits of addr_o at beat k equal the captured start low bits plus k, modulo 4.
- R6: Bits above bit 1 of addr_o stay at their captured value until the next load.
- R7: A load during a burst restarts the burst at the newly presented address with beat_o equal to 0. A load takes priority over an advance in the same cycle.
- R8: With no load and adv_n high, addr_o and beat_o hold their values.
- R9: The order is sampled only at load. A change of order_sel during a burst does not alter the sequence.
- R10: During and right after synchronous reset (rst high), addr_o and beat_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| addr_i | input | ADDR_W | Address presented with a strobe |
| proc_strb_n | input | 1 | Processor address strobe, active low, qualified by cs1_n |
| ctrl_strb_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| order_sel | input | 1 | Burst order: 1 interleaved, 0 linear |
| cs1_n | input | 1 | First chip select, active low, gates the processor strobe |
| addr_o | output | ADDR_W | Current burst address |
| beat_o | output | BEAT_W | Index of the current beat |

## Verification
The bench builds the block with ADDR_W = 10 and BEAT_W = 2. This keeps every burst at four beats while the upper field stays small enough to give it all-ones, all-zeros and mixed patterns. Those patterns make any leak from the low-bit sequencing into the upper bits visible. With a two-bit beat field, every start offset can be combined with both orders. Carry wrap in linear order and the XOR pattern in interleaved order are then compared beat by beat.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

    typedef enum logic {
        ORD_LINEAR     = 1'b0,
        ORD_INTERLEAVE = 1'b1
    } order_e;

    localparam order_e ORDER_AFTER_RESET = ORD_INTERLEAVE;

    function automatic order_e order_from_pin(input logic pin);
        return pin ? ORD_INTERLEAVE : ORD_LINEAR;
    endfunction

endpackage

// File: rtl/burst_strobe_qual.sv
module burst_strobe_qual (
    input  logic proc_strb_n,
    input  logic ctrl_strb_n,
    input  logic cs1_n,
    output logic load
);
    logic proc_hit;
    logic ctrl_hit;

    always_comb begin
        proc_hit = !proc_strb_n && !cs1_n;
        ctrl_hit = !ctrl_strb_n;
        load     = proc_hit || ctrl_hit;
    end
endmodule

// File: rtl/burst_beat_counter.sv
module burst_beat_counter #(
    parameter int BEAT_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              step,
    output logic [BEAT_W-1:0] beat
);
    logic [BEAT_W-1:0] beat_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            beat_q <= '0;
        end else if (load) begin
            beat_q <= '0;
        end else if (step) begin
            beat_q <= beat_q + 1'b1;
        end
    end

    assign beat = beat_q;

    AST_BEAT_STEP: assert property (@(posedge clk) disable iff (rst)
        (!load && step) |=> beat == BEAT_W'($past(beat) + 1'b1)); // R3
    AST_BEAT_RESTART: assert property (@(posedge clk) disable iff (rst)
        load |=> beat == '0); // R7
endmodule

// File: rtl/burst_order_map.sv
module burst_order_map
    import burst_seq_pkg::*;
#(
    parameter int BEAT_W = 2
) (
    input  logic [BEAT_W-1:0] start_low,
    input  logic [BEAT_W-1:0] beat,
    input  order_e            order,
    output logic [BEAT_W-1:0] low_out
);
    logic [BEAT_W-1:0] xor_low;
    logic [BEAT_W-1:0] sum_low;

    for (genvar b = 0; b < BEAT_W; b++) begin : g_xor_bit
        assign xor_low[b] = start_low[b] ^ beat[b];
    end

    always_comb begin
        sum_low = start_low + beat;
        low_out = (order == ORD_INTERLEAVE) ? xor_low : sum_low;
    end
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
    import burst_seq_pkg::*;
#(
    parameter int ADDR_W = 18,
    parameter int BEAT_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              proc_strb_n,
    input  logic              ctrl_strb_n,
    input  logic              adv_n,
    input  logic              order_sel,
    input  logic              cs1_n,
    output logic [ADDR_W-1:0] addr_o,
    output logic [BEAT_W-1:0] beat_o
);
    localparam int UP_W = ADDR_W - BEAT_W;

    typedef struct packed {
        logic [UP_W-1:0]   upper;
        logic [BEAT_W-1:0] start_low;
        order_e            order;
    } burst_base_t;

    burst_base_t       base_q;
    logic              load;
    logic [BEAT_W-1:0] beat;
    logic [BEAT_W-1:0] low_now;

    burst_strobe_qual u_qual (
        .proc_strb_n (proc_strb_n),
        .ctrl_strb_n (ctrl_strb_n),
        .cs1_n       (cs1_n),
        .load        (load)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q.upper     <= '0;
            base_q.start_low <= '0;
            base_q.order     <= ORDER_AFTER_RESET;
        end else if (load) begin
            base_q.upper     <= addr_i[ADDR_W-1:BEAT_W];
            base_q.start_low <= addr_i[BEAT_W-1:0];
            base_q.order     <= order_from_pin(order_sel);
        end
    end

    burst_beat_counter #(.BEAT_W(BEAT_W)) u_cnt (
        .clk  (clk),
        .rst  (rst),
        .load (load),
        .step (!adv_n),
        .beat (beat)
    );

    burst_order_map #(.BEAT_W(BEAT_W)) u_map (
        .start_low (base_q.start_low),
        .beat      (beat),
        .order     (base_q.order),
        .low_out   (low_now)
    );

    assign addr_o = {base_q.upper, low_now};
    assign beat_o = beat;

    AST_CTRL_LOAD: assert property (@(posedge clk) disable iff (rst)
        !ctrl_strb_n |=> (addr_o == $past(addr_i)) && (beat_o == '0)); // R1
    AST_PROC_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (cs1_n && ctrl_strb_n && adv_n) |=> $stable(addr_o) && $stable(beat_o)); // R2
    AST_UPPER_HOLD: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(addr_o[ADDR_W-1:BEAT_W])); // R6
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (proc_strb_n && ctrl_strb_n && adv_n) |=> $stable(addr_o) && $stable(beat_o)); // R8
endmodule

// File: tb/burst_addr_seq_tb_top.sv
`timescale 1ns/1ps
module burst_addr_seq_tb_top;
    localparam int AW = 10;
    localparam int BW = 2;

    logic          clk = 1'b0;
    logic          rst;
    logic [AW-1:0] addr_i;
    logic          proc_strb_n, ctrl_strb_n, adv_n, order_sel, cs1_n;
    logic [AW-1:0] addr_o;
    logic [BW-1:0] beat_o;

    int n_chk  = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    burst_addr_seq #(.ADDR_W(AW), .BEAT_W(BW)) dut_i (
        .clk (clk), .rst (rst), .addr_i (addr_i),
        .proc_strb_n (proc_strb_n), .ctrl_strb_n (ctrl_strb_n),
        .adv_n (adv_n), .order_sel (order_sel), .cs1_n (cs1_n),
        .addr_o (addr_o), .beat_o (beat_o)
    );

    function automatic logic [AW-1:0] exp_addr(input logic [AW-1:0] st,
                                               input logic [BW-1:0] k,
                                               input logic ilv);
        logic [BW-1:0] lo;
        lo = ilv ? (st[BW-1:0] ^ k) : BW'(st[BW-1:0] + k);
        return {st[AW-1:BW], lo};
    endfunction

    task automatic chk(input string req, input logic [AW-1:0] ea, input logic [BW-1:0] eb);
        n_chk++;
        if (addr_o !== ea || beat_o !== eb) begin
            n_fail++;
            $display("FAIL %s: addr=%h beat=%0d expected addr=%h beat=%0d",
                     req, addr_o, beat_o, ea, eb);
        end
    endtask

    task automatic idle();
        proc_strb_n = 1'b1; ctrl_strb_n = 1'b1; adv_n = 1'b1;
    endtask

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic ctrl_load(input logic [AW-1:0] a, input logic ilv, input logic cs);
        addr_i = a; order_sel = ilv; cs1_n = cs; ctrl_strb_n = 1'b0; proc_strb_n = 1'b1; adv_n = 1'b1;
        tick(); idle();
    endtask

    task automatic t_reset();
        rst = 1'b1; idle(); addr_i = '1; order_sel = 1'b1; cs1_n = 1'b0;
        tick(); tick();
        chk("R10 in reset", '0, '0);
        rst = 1'b0;
        tick();
        chk("R10 after reset", '0, '0);
    endtask

    task automatic t_burst(input logic [AW-1:0] st, input logic ilv, input string req);
        ctrl_load(st, ilv, 1'b1);
        chk({req, " R1 load"}, st, '0);
        for (int k = 1; k <= 4; k++) begin
            adv_n = 1'b0;
            tick();
            chk({req, " R3 R6 beat"}, exp_addr(st, BW'(k), ilv), BW'(k));
        end
        idle();
        chk({req, " R3 wrap"}, st, '0);
    endtask

    task automatic t_proc();
        ctrl_load(10'h155, 1'b1, 1'b1);
        addr_i = 10'h2AA; cs1_n = 1'b1; proc_strb_n = 1'b0;
        tick(); idle();
        chk("R2 proc ignored cs1_n high", 10'h155, '0);
        addr_i = 10'h2AA; cs1_n = 1'b0; proc_strb_n = 1'b0;
        tick(); idle();
        chk("R2 proc load cs1_n low", 10'h2AA, '0);
    endtask

    task automatic t_hold();
        ctrl_load(10'h0C1, 1'b0, 1'b0);
        adv_n = 1'b0; tick(); idle();
        chk("R5 step", 10'h0C2, 2'd1);
        addr_i = 10'h3FF; order_sel = 1'b1;
        tick(); tick();
        chk("R8 hold", 10'h0C2, 2'd1);
    endtask

    task automatic t_restart();
        ctrl_load(10'h201, 1'b1, 1'b0);
        adv_n = 1'b0; tick();
        chk("R4 beat1", 10'h200, 2'd1);
        addr_i = 10'h0E3; order_sel = 1'b0; ctrl_strb_n = 1'b0; adv_n = 1'b0;
        tick(); idle();
        chk("R7 restart wins over advance", 10'h0E3, '0);
        adv_n = 1'b0; tick(); idle();
        chk("R7 R5 beat1 after restart", 10'h0E0, 2'd1);
    endtask

    task automatic t_mode_latch();
        ctrl_load(10'h102, 1'b0, 1'b0);
        order_sel = 1'b1; adv_n = 1'b0;
        tick();
        chk("R9 beat1 linear kept", 10'h103, 2'd1);
        tick(); idle();
        chk("R9 beat2 linear kept", 10'h100, 2'd2);
    endtask

    initial begin
        #(200000 * 5);
        n_fail++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_burst(10'h3FD, 1'b1, "R4 ilv st1 ones");
        t_burst(10'h002, 1'b1, "R4 ilv st2 zeros");
        t_burst(10'h2AB, 1'b0, "R5 lin st3");
        t_burst(10'h150, 1'b0, "R5 lin st0");
        t_proc();
        t_hold();
        t_restart();
        t_mode_latch();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule